// File: doc/BRIEF.md
# Serial Word Buffer with Watermark Events

This block sits between a bus-facing register layer and a serial shift engine. It holds two word queues of 16-bit entries. Software fills the transmit queue and the engine drains it. The engine fills the receive queue and software drains it. The depth of both queues is set by one parameter, 32 or 64 words. Both fill levels are visible on output ports at all times.

The block turns the fill levels into events. A receive-full interrupt fires once the receive level passes a programmed threshold. Four sticky error and event flags record overflow, underflow and a chip-select release. A mask register gates the raw flags into a single interrupt line, and a clear strobe with a one-hot encoding resets the sticky flags.

Two DMA request lines follow their own watermarks. An optional idle timer raises a single-word receive request when a few words sit in the receive queue but not enough of them to fill a burst. Clearing the global enable flushes both queues.

Top module: `spi_word_buffer`

## Requirements
- R1: Each queue returns words in the order they were written. `tx_level_o` and `rx_level_o` give the current occupancy, from 0 up to DEPTH.
- R2: Raw bit 4 (receive full) is 1 exactly when `rx_level_o` is strictly greater than `rx_thresh_i`. To get an event after N words, program N-1.
- R3: A write into a full queue is dropped and the queue keeps its contents. A bus write to a full transmit queue sets raw bit 1. An engine push into a full receive queue sets raw bit 3.
- R4: A bus read of an empty receive queue returns 0 on `rx_rdata_o` and sets raw bit 2.
- R5: `irq_stat_o` equals `raw_stat_o` ANDed with the mask, which is written through `mask_wr_i`. `irq_o` is the OR of `irq_stat_o`, so a mask of 0 keeps `irq_o` low.
- R6: A clear strobe takes these write-one bits, and a flag set in the same cycle as its clear stays set:
  - bit 0 clears all sticky flags;
  - bit 1 clears only the underflow flag (raw bit 2);
  - bit 2 clears only the receive overflow flag (raw bit 3);
  - bit 3 clears only the transmit overflow flag (raw bit 1).
- R7: `tx_dma_req_o` is high while `dma_en_i[1]` is set and `tx_level_o` is less than or equal to `tx_dma_wm_i`.
- R8: `rx_dma_req_o` is high while `dma_en_i[0]` is set and `rx_level_o` is at least `rx_dma_lvl_i`+1. `rx_dma_lvl_i` is the burst size minus one, for bursts of 1, 2, 4, 8 or 16 words.
- R9: `tmo_ctrl_i` holds the idle threshold in bits 15:0, the counter enable in bit 16 and the single-request enable in bit 18. With the counter enabled, the count runs while the receive queue is non-empty and below the burst level. Any receive push or pop restarts it. Once the count reaches the threshold, and if single-request and `dma_en_i[0]` are both set, `rx_single_req_o` goes high until the receive queue changes.
- R10: While `enable_i` is low, both queues are emptied, writes are ignored, and the idle count is held at zero.
- R11: Raw bit 0 shows live that the transmit queue is empty. Raw bit 6 is set by a pulse on `cs_release_i` and is cleared only by clear bit 0. Raw bit 5 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Global enable; low flushes both queues |
| tx_wr_i | input | 1 | Bus write strobe for the transmit queue |
| tx_wdata_i | input | 16 | Bus write word |
| rx_rd_i | input | 1 | Bus read strobe for the receive queue |
| rx_rdata_o | output | 16 | Receive head word, 0 when empty |
| eng_tx_pop_i | input | 1 | Engine takes the transmit head |
| eng_tx_data_o | output | 16 | Transmit head word |
| eng_rx_push_i | input | 1 | Engine stores a received word |
| eng_rx_data_i | input | 16 | Received word |
| cs_release_i | input | 1 | Pulse when chip select goes inactive |
| rx_thresh_i | input | LVL_W | Receive-full threshold |
| tx_dma_wm_i | input | LVL_W | Transmit DMA watermark |
| rx_dma_lvl_i | input | 4 | Receive burst size minus one |
| dma_en_i | input | 2 | Bit 0 receive DMA, bit 1 transmit DMA |
| tmo_ctrl_i | input | 32 | Idle timer control |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 7 | Mask value |
| clr_wr_i | input | 1 | Clear strobe |
| clr_wdata_i | input | 4 | Clear bits |
| tx_level_o | output | LVL_W | Transmit occupancy |
| rx_level_o | output | LVL_W | Receive occupancy |
| raw_stat_o | output | 7 | Raw status |
| mask_o | output | 7 | Mask register |
| irq_stat_o | output | 7 | Masked status |
| irq_o | output | 1 | Interrupt |
| tx_dma_req_o | output | 1 | Transmit DMA request |
| rx_dma_req_o | output | 1 | Receive burst DMA request |
| rx_single_req_o | output | 1 | Receive single-word DMA request |

## Verification
The bench probes the receive threshold one word below and at the trip point. A design using greater-or-equal would fire one word early. It also writes into a full transmit queue and then reads back the head word. A design that overwrote an entry or bumped the level would return the wrong word or report DEPTH+1.

Each clear bit is applied alone so that a swapped encoding shows up as a flag surviving or vanishing. The idle timer is sampled well before and well after its threshold, and again after a pop. A timer that ignored activity or never saturated would hold the single request at the wrong time.

// File: rtl/spi_buf_pkg.sv
package spi_buf_pkg;
  localparam int WORD_W  = 16;
  localparam int STAT_W  = 7;
  localparam int CLR_W   = 4;
  localparam int BURST_W = 4;
  localparam int TMO_W   = 16;
  localparam int TMO_EN_BIT  = 16;
  localparam int TMO_ONE_BIT = 18;
  // sticky slot order inside irq_status
  localparam int S_TXOVF = 0;
  localparam int S_RXUNF = 1;
  localparam int S_RXOVF = 2;
  localparam int S_CSOFF = 3;
  localparam int N_STICKY = 4;
endpackage

// File: rtl/word_fifo.sv
module word_fifo #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = PTR_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic [LVL_W-1:0] level_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             drop_o,
  output logic             starve_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic             push_ok, pop_ok;

  assign full_o   = (level_o == LVL_W'(DEPTH));
  assign empty_o  = (level_o == '0);
  assign push_ok  = push_i && !full_o && !flush_i;
  assign pop_ok   = pop_i && !empty_o && !flush_i;
  assign drop_o   = push_i && full_o && !flush_i;
  assign starve_o = pop_i && empty_o && !flush_i;
  assign data_o   = empty_o ? '0 : mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= '0;
      rd_q    <= '0;
      level_o <= '0;
    end else if (flush_i) begin
      wr_q    <= '0;
      rd_q    <= '0;
      level_o <= '0;
    end else begin
      if (push_ok) wr_q <= wr_q + 1'b1;
      if (pop_ok)  rd_q <= rd_q + 1'b1;
      level_o <= level_o + LVL_W'(push_ok) - LVL_W'(pop_ok);
    end
  end

  p_level_cap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= LVL_W'(DEPTH));
  p_drop_full_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && full_o && !pop_i && !flush_i |=> $stable(level_o));
  p_empty_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> data_o == '0);
endmodule

// File: rtl/irq_status.sv
module irq_status
  import spi_buf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_empty_i,
  input  logic              rx_full_i,
  input  logic [N_STICKY-1:0] set_i,
  input  logic              mask_wr_i,
  input  logic [STAT_W-1:0] mask_wdata_i,
  input  logic              clr_wr_i,
  input  logic [CLR_W-1:0]  clr_wdata_i,
  output logic [STAT_W-1:0] raw_o,
  output logic [STAT_W-1:0] mask_o,
  output logic [STAT_W-1:0] masked_o,
  output logic              irq_o
);
  logic [N_STICKY-1:0] sticky_q, sel_clr;
  logic                clr_all;

  assign clr_all = clr_wr_i && clr_wdata_i[0];
  // per-slot selective clear: tx ovf <- bit3, rx unf <- bit1, rx ovf <- bit2, cs none
  assign sel_clr = clr_wr_i ? {1'b0, clr_wdata_i[2], clr_wdata_i[1], clr_wdata_i[3]}
                            : '0;

  for (genvar g = 0; g < N_STICKY; g++) begin : g_sticky
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         sticky_q[g] <= 1'b0;
      else if (set_i[g])                   sticky_q[g] <= 1'b1;
      else if (clr_all || sel_clr[g])      sticky_q[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_o <= '0;
    else if (mask_wr_i) mask_o <= mask_wdata_i;
  end

  assign raw_o = {sticky_q[S_CSOFF], 1'b0, rx_full_i, sticky_q[S_RXOVF],
                  sticky_q[S_RXUNF], sticky_q[S_TXOVF], tx_empty_i};
  assign masked_o = raw_o & mask_o;
  assign irq_o    = |masked_o;

  p_clear_all_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_all && (set_i == '0) |=> sticky_q == '0);
  p_mask_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_o == '0) |-> !irq_o);
  p_cs_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sticky_q[S_CSOFF] && !clr_all |=> sticky_q[S_CSOFF]);
endmodule

// File: rtl/rx_timeout.sv
module rx_timeout
  import spi_buf_pkg::*;
#(
  parameter int LVL_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             cnt_en_i,
  input  logic             single_en_i,
  input  logic             dma_rx_en_i,
  input  logic [TMO_W-1:0] thr_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic [LVL_W-1:0] burst_i,
  input  logic             activity_i,
  output logic             single_req_o
);
  logic [TMO_W-1:0] cnt_q;
  logic             window, hit;

  assign window = enable_i && cnt_en_i && (rx_level_i != '0) && (rx_level_i < burst_i);
  assign hit    = window && !activity_i && (cnt_q >= thr_i);
  assign single_req_o = hit && single_en_i && dma_rx_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (!window || activity_i) cnt_q <= '0;
    else if (cnt_q < thr_i)        cnt_q <= cnt_q + 1'b1;
  end

  p_single_nonempty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    single_req_o |-> rx_level_i != '0);
  p_idle_reset_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> cnt_q == '0);
endmodule

// File: rtl/spi_word_buffer.sv
module spi_word_buffer
  import spi_buf_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              tx_wr_i,
  input  logic [WORD_W-1:0] tx_wdata_i,
  input  logic              rx_rd_i,
  output logic [WORD_W-1:0] rx_rdata_o,
  input  logic              eng_tx_pop_i,
  output logic [WORD_W-1:0] eng_tx_data_o,
  input  logic              eng_rx_push_i,
  input  logic [WORD_W-1:0] eng_rx_data_i,
  input  logic              cs_release_i,
  input  logic [LVL_W-1:0]  rx_thresh_i,
  input  logic [LVL_W-1:0]  tx_dma_wm_i,
  input  logic [BURST_W-1:0] rx_dma_lvl_i,
  input  logic [1:0]        dma_en_i,
  input  logic [31:0]       tmo_ctrl_i,
  input  logic              mask_wr_i,
  input  logic [STAT_W-1:0] mask_wdata_i,
  input  logic              clr_wr_i,
  input  logic [CLR_W-1:0]  clr_wdata_i,
  output logic [LVL_W-1:0]  tx_level_o,
  output logic [LVL_W-1:0]  rx_level_o,
  output logic [STAT_W-1:0] raw_stat_o,
  output logic [STAT_W-1:0] mask_o,
  output logic [STAT_W-1:0] irq_stat_o,
  output logic              irq_o,
  output logic              tx_dma_req_o,
  output logic              rx_dma_req_o,
  output logic              rx_single_req_o
);
  logic flush;
  logic tx_full, tx_empty, tx_drop, tx_starve;
  logic rx_full_q, rx_empty, rx_drop, rx_starve;
  logic [LVL_W-1:0] burst;
  logic [N_STICKY-1:0] set_vec;

  assign flush = !enable_i;
  assign burst = LVL_W'(rx_dma_lvl_i) + 1'b1;

  word_fifo #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_tx (
    .clk_i, .rst_ni, .flush_i(flush),
    .push_i(tx_wr_i), .data_i(tx_wdata_i),
    .pop_i(eng_tx_pop_i), .data_o(eng_tx_data_o),
    .level_o(tx_level_o), .full_o(tx_full), .empty_o(tx_empty),
    .drop_o(tx_drop), .starve_o(tx_starve)
  );

  word_fifo #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_rx (
    .clk_i, .rst_ni, .flush_i(flush),
    .push_i(eng_rx_push_i), .data_i(eng_rx_data_i),
    .pop_i(rx_rd_i), .data_o(rx_rdata_o),
    .level_o(rx_level_o), .full_o(rx_full_q), .empty_o(rx_empty),
    .drop_o(rx_drop), .starve_o(rx_starve)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[S_TXOVF] = tx_drop;
    set_vec[S_RXUNF] = rx_starve;
    set_vec[S_RXOVF] = rx_drop;
    set_vec[S_CSOFF] = cs_release_i;
  end

  irq_status u_irq (
    .clk_i, .rst_ni,
    .tx_empty_i(tx_empty),
    .rx_full_i(rx_level_o > rx_thresh_i),
    .set_i(set_vec),
    .mask_wr_i, .mask_wdata_i, .clr_wr_i, .clr_wdata_i,
    .raw_o(raw_stat_o), .mask_o(mask_o), .masked_o(irq_stat_o), .irq_o(irq_o)
  );

  rx_timeout #(.LVL_W(LVL_W)) u_tmo (
    .clk_i, .rst_ni,
    .enable_i,
    .cnt_en_i(tmo_ctrl_i[TMO_EN_BIT]),
    .single_en_i(tmo_ctrl_i[TMO_ONE_BIT]),
    .dma_rx_en_i(dma_en_i[0]),
    .thr_i(tmo_ctrl_i[TMO_W-1:0]),
    .rx_level_i(rx_level_o),
    .burst_i(burst),
    .activity_i(eng_rx_push_i || rx_rd_i),
    .single_req_o(rx_single_req_o)
  );

  assign tx_dma_req_o = enable_i && dma_en_i[1] && (tx_level_o <= tx_dma_wm_i);
  assign rx_dma_req_o = enable_i && dma_en_i[0] && (rx_level_o >= burst);

  p_flush_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (tx_level_o == '0) && (rx_level_o == '0));
  p_unf_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && rx_rd_i && rx_empty && !clr_wr_i |=> raw_stat_o[2]);
  p_ovf_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && tx_wr_i && tx_full && !clr_wr_i |=> raw_stat_o[1]);
endmodule

// File: tb/spi_word_buffer_test.sv
module spi_word_buffer_test;
  localparam int DEPTH = 32;
  localparam int LVL_W = $clog2(DEPTH) + 1;

  logic clk = 0, rst_n = 0, en = 0;
  logic tx_wr = 0, rx_rd = 0, t_pop = 0, r_push = 0, cs_rel = 0;
  logic [15:0] tx_wd = 0, r_data = 0;
  logic [15:0] rx_rdata, t_data;
  logic [LVL_W-1:0] rx_thr = 0, tx_wm = 0, tx_lvl, rx_lvl;
  logic [3:0] rx_dl = 0;
  logic [1:0] dma_en = 0;
  logic [31:0] tmo = 0;
  logic m_wr = 0, c_wr = 0;
  logic [6:0] m_wd = 0, raw, msk, ist;
  logic [3:0] c_wd = 0;
  logic irq, txreq, rxreq, onereq;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  spi_word_buffer #(.DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en),
    .tx_wr_i(tx_wr), .tx_wdata_i(tx_wd), .rx_rd_i(rx_rd), .rx_rdata_o(rx_rdata),
    .eng_tx_pop_i(t_pop), .eng_tx_data_o(t_data),
    .eng_rx_push_i(r_push), .eng_rx_data_i(r_data), .cs_release_i(cs_rel),
    .rx_thresh_i(rx_thr), .tx_dma_wm_i(tx_wm), .rx_dma_lvl_i(rx_dl),
    .dma_en_i(dma_en), .tmo_ctrl_i(tmo),
    .mask_wr_i(m_wr), .mask_wdata_i(m_wd), .clr_wr_i(c_wr), .clr_wdata_i(c_wd),
    .tx_level_o(tx_lvl), .rx_level_o(rx_lvl), .raw_stat_o(raw), .mask_o(msk),
    .irq_stat_o(ist), .irq_o(irq), .tx_dma_req_o(txreq), .rx_dma_req_o(rxreq),
    .rx_single_req_o(onereq)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_write(logic [15:0] d);
    tx_wr = 1; tx_wd = d; step(); tx_wr = 0;
  endtask
  task automatic eng_push(logic [15:0] d);
    r_push = 1; r_data = d; step(); r_push = 0;
  endtask
  task automatic eng_pop(string tag, logic [15:0] exp);
    check(tag, t_data, exp); t_pop = 1; step(); t_pop = 0;
  endtask
  task automatic bus_read(string tag, logic [15:0] exp);
    check(tag, rx_rdata, exp); rx_rd = 1; step(); rx_rd = 0;
  endtask
  task automatic clear(logic [3:0] v);
    c_wr = 1; c_wd = v; step(); c_wr = 0;
  endtask
  task automatic flush_all;
    en = 0; step(); en = 1; clear(4'h1);
  endtask

  task automatic t_reset;
    check("R1 reset tx level", tx_lvl, 0);
    check("R1 reset rx level", rx_lvl, 0);
    check("R11 reset raw", raw, 7'h01);
    check("R5 reset irq", irq, 0);
  endtask

  task automatic t_order;
    bus_write(16'hA001); bus_write(16'hA002); bus_write(16'hA003);
    check("R1 tx level 3", tx_lvl, 3);
    check("R11 tx empty bit low", raw[0], 0);
    eng_pop("R1 tx order 0", 16'hA001);
    eng_pop("R1 tx order 1", 16'hA002);
    eng_pop("R1 tx order 2", 16'hA003);
    check("R11 tx empty bit high", raw[0], 1);
    eng_push(16'h5151); eng_push(16'h5252);
    check("R1 rx level 2", rx_lvl, 2);
    bus_read("R1 rx order 0", 16'h5151);
    bus_read("R1 rx order 1", 16'h5252);
  endtask

  task automatic t_thresh;
    rx_thr = 2;
    eng_push(1); eng_push(2);
    check("R2 at threshold no full", raw[4], 0);
    eng_push(3);
    check("R2 above threshold full", raw[4], 1);
    flush_all();
    check("R2 cleared after flush", raw[4], 0);
  endtask

  task automatic t_overflow;
    for (int i = 0; i < DEPTH; i++) bus_write(16'(16'h100 + i));
    check("R3 no flag when exactly full", raw[1], 0);
    bus_write(16'hDEAD);
    check("R3 level held", tx_lvl, DEPTH);
    check("R3 tx ovf flag", raw[1], 1);
    eng_pop("R3 head kept", 16'h100);
    for (int i = 0; i < DEPTH; i++) eng_push(16'(i));
    eng_push(16'hBEEF);
    check("R3 rx ovf flag", raw[3], 1);
    check("R3 rx level held", rx_lvl, DEPTH);
    flush_all();
  endtask

  task automatic t_underflow;
    bus_read("R4 empty read zero", 16'h0000);
    check("R4 unf flag", raw[2], 1);
    check("R1 level stays 0", rx_lvl, 0);
  endtask

  task automatic t_clear;
    bus_write(0); clear(4'h0);
    for (int i = 0; i < DEPTH; i++) bus_write(1);
    for (int i = 0; i < DEPTH + 1; i++) eng_push(2);
    bus_read("R4 pre clear", 16'h0002);
    flush_all(); // leaves all flags clean
    rx_rd = 1; step(); rx_rd = 0;
    for (int i = 0; i < DEPTH + 1; i++) bus_write(1);
    for (int i = 0; i < DEPTH + 1; i++) eng_push(2);
    check("R6 three flags set", raw[3:1], 3'b111);
    clear(4'h2);
    check("R6 bit1 clears unf only", raw[3:1], 3'b101);
    clear(4'h4);
    check("R6 bit2 clears rx ovf only", raw[3:1], 3'b001);
    clear(4'h8);
    check("R6 bit3 clears tx ovf", raw[3:1], 3'b000);
    flush_all();
  endtask

  task automatic t_mask;
    rx_thr = 0; eng_push(7); rx_rd = 1; step(); rx_rd = 0;
    rx_rd = 1; step(); rx_rd = 0; // underflow
    eng_push(8);
    m_wr = 1; m_wd = 7'h10; step(); m_wr = 0;
    check("R5 mask readback", msk, 7'h10);
    check("R5 masked status", ist, 7'h10);
    check("R5 irq high", irq, 1);
    m_wr = 1; m_wd = 7'h00; step(); m_wr = 0;
    check("R5 zero mask silences", irq, 0);
    check("R5 masked zero", ist, 0);
    flush_all();
  endtask

  task automatic t_txdma;
    tx_wm = 4; dma_en = 2'b10;
    for (int i = 0; i < 5; i++) bus_write(16'(i));
    check("R7 above watermark low", txreq, 0);
    eng_pop("R7 pop", 16'h0);
    check("R7 at watermark high", txreq, 1);
    dma_en = 2'b00; step();
    check("R7 disabled low", txreq, 0);
    flush_all();
  endtask

  task automatic t_rxdma;
    rx_dl = 3; dma_en = 2'b01;
    eng_push(1); eng_push(2); eng_push(3);
    check("R8 below burst low", rxreq, 0);
    eng_push(4);
    check("R8 burst reached high", rxreq, 1);
    flush_all();
  endtask

  task automatic t_timeout;
    rx_dl = 3; dma_en = 2'b01;
    tmo = 32'h0005_0005; // counter + single enable, threshold 5
    eng_push(9);
    step(2);
    check("R9 early no request", onereq, 0);
    step(8);
    check("R9 request after idle", onereq, 1);
    bus_read("R9 pop data", 16'h9);
    check("R9 request drops on empty", onereq, 0);
    tmo = 32'h0001_0005; // single disabled
    eng_push(5); step(10);
    check("R9 single disabled", onereq, 0);
    tmo = 0;
    flush_all();
  endtask

  task automatic t_disable;
    bus_write(1); eng_push(2);
    en = 0; step();
    check("R10 tx flushed", tx_lvl, 0);
    check("R10 rx flushed", rx_lvl, 0);
    bus_write(3);
    check("R10 write ignored while off", tx_lvl, 0);
    en = 1; step();
  endtask

  task automatic t_cs;
    clear(4'h1);
    cs_rel = 1; step(); cs_rel = 0;
    check("R11 cs flag set", raw[6], 1);
    clear(4'hE);
    check("R11 cs survives selective clear", raw[6], 1);
    check("R11 bit5 zero", raw[5], 0);
    clear(4'h1);
    check("R11 cs cleared by all", raw[6], 0);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1;
    step();
    t_reset();
    en = 1; step();
    t_order();
    t_thresh();
    t_overflow();
    t_underflow();
    clear(4'h1);
    t_clear();
    t_mask();
    t_txdma();
    t_rxdma();
    t_timeout();
    t_disable();
    t_cs();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule